// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small processor core. A call instruction or an interrupt branch raises `push_en` and presents the current program counter on `push_addr`. The block then stores that value on top of an eight-level stack. A return, a return-with-literal or a return-from-interrupt raises `pop_en`. In that same cycle `pop_addr` carries the newest stored address. The core loads this address into its program counter, and the stack then drops one level.

The pointer is internal and has no read or write path. The storage is a ring. The block has no full or empty flags and never refuses a request. A ninth push without pops overwrites the oldest level. Popping more levels than were pushed walks backwards through the ring and returns stale entries. The block touches nothing outside its own storage. In particular, the upper program-counter latch of the core is not affected by any push or pop.

Top module: `ret_ring_stack`

## Requirements
- R1: After reset the pointer is zero and every level holds zero, so `pop_addr` reads 0.
- R2: A push with no pop stores `push_addr` as the new top, and `pop_addr` shows it from the next cycle.
- R3: `pop_addr` always shows the newest unpopped entry. A pop with no push removes that entry, so in the next cycle the next older entry is shown.
- R4: With `DEPTH` levels, push number `DEPTH+1` overwrites the entry of push 1, and push `DEPTH+2` overwrites push 2. No flag or stall results.
- R5: A pop when nothing remains pushed wraps the pointer downwards modulo `DEPTH` and delivers whatever that level holds.
- R6: A push and a pop in the same cycle deliver the current top on `pop_addr` in that cycle. The top is then replaced by `push_addr`, and the number of levels in use is unchanged.
- R7: With neither push nor pop, the stored entries and `pop_addr` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Store `push_addr` as the new top |
| pop_en | input | 1 | Remove the top entry |
| push_addr | input | AW (13) | Address to be stored |
| pop_addr | output | AW (13) | Current top entry, valid in the pop cycle |

## Verification
The bench builds the block with its default parameters: 8 levels of 13 bits. With these values a wrap in either direction takes only nine pushes or a few pops after reset, so overwrite of the oldest level (R4) and underflow into stale levels (R5) can be reached directly. They can also be reached repeatedly during a long pseudo-random mix of push, pop, combined and idle cycles. A level counter in the bench is never reduced modulo the depth, so it can also tell a correct wrap from a stack that saturates.

// File: rtl/ret_ring_stack.sv
module ret_ring_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] slot [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] top_idx;

  assign top_idx  = ptr - PW'(1);
  assign pop_addr = slot[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      unique case ({push_en, pop_en})
        2'b10: begin
          slot[ptr] <= push_addr;
          ptr       <= ptr + PW'(1);
        end
        2'b01: ptr <= top_idx;
        2'b11: slot[top_idx] <= push_addr;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ret_ring_stack_chk.sv
module ret_ring_stack_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     push_en,
  input logic                     pop_en,
  input logic [AW-1:0]            push_addr,
  input logic [AW-1:0]            pop_addr,
  input logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int PW = $clog2(DEPTH);

  a_r1_reset_ptr: assert property (@(posedge clk) !rst_n |=> ptr == '0);
  a_r1_reset_top: assert property (@(posedge clk) !rst_n |=> pop_addr == '0);

  a_r2_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |=> pop_addr == $past(push_addr));

  a_r4_push_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !pop_en) |=> ptr == PW'($past(ptr) + 1));

  a_r5_pop_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en) |=> ptr == PW'($past(ptr) - 1));

  a_r6_replace_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en) |=> (pop_addr == $past(push_addr)) && $stable(ptr));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !pop_en) |=> $stable(pop_addr) && $stable(ptr));
endmodule

bind ret_ring_stack ret_ring_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
  .push_addr(push_addr), .pop_addr(pop_addr), .ptr(ptr)
);

// File: tb/sim_ret_ring_stack.sv
`timescale 1ns/1ps
module sim_ret_ring_stack;
  localparam int DEPTH = 8;
  localparam int AW    = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_en = 1'b0;
  logic          pop_en = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] pop_addr;

  int checks = 0;
  int errors = 0;
  int mdl [DEPTH];
  int lvl = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ret_ring_stack #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .pop_en(pop_en),
    .push_addr(push_addr), .pop_addr(pop_addr)
  );

  function automatic int wrap(input int v);
    return ((v % DEPTH) + DEPTH) % DEPTH;
  endfunction

  function automatic int model_top();
    return mdl[wrap(lvl - 1)];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: pop_addr=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push_en = 1'b0; pop_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lvl = 0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    check("R1", int'(pop_addr), 0);
  endtask

  task automatic step(input string tag, input bit psh, input bit pp, input int d);
    push_en = psh; pop_en = pp; push_addr = AW'(d);
    if (pp) check(tag, int'(pop_addr), model_top());
    @(posedge clk);
    if (psh && !pp) begin mdl[wrap(lvl)] = d; lvl++; end
    else if (pp && !psh) lvl--;
    else if (psh && pp) mdl[wrap(lvl - 1)] = d;
    @(negedge clk);
    push_en = 1'b0; pop_en = 1'b0;
    check(tag, int'(pop_addr), model_top());
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=hang exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    for (int i = 0; i < 3; i++) step("R5", 1'b0, 1'b1, 0);
    step("R7", 1'b0, 1'b0, 0);

    do_reset();
    for (int i = 1; i <= DEPTH + 1; i++) step("R2", 1'b1, 1'b0, 'h100 + i * 7);
    for (int i = 0; i < DEPTH + 2; i++) step("R4", 1'b0, 1'b1, 0);
    step("R7", 1'b0, 1'b0, 'h1FFF);
    step("R3", 1'b1, 1'b0, 'h0AB);
    step("R3", 1'b1, 1'b0, 'h0CD);
    step("R6", 1'b1, 1'b1, 'h1234);
    step("R3", 1'b0, 1'b1, 0);
    step("R3", 1'b0, 1'b1, 0);

    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R3", lfsr[0], lfsr[1], int'(lfsr[15:3]));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule